// File: doc/BRIEF.md
# Nibble-Field Prioritized Interrupt Controller

This block gathers 28 interrupt sources and presents the CPU with the highest active priority level and the index of the source that owns it. Each source has one 4-bit field inside one of four 32-bit control registers. The low three bits of a field hold the priority, and a priority of zero masks the source. The top bit of a field has two uses. On a write it is the strobe that lets the write take effect, and for edge sources that same write clears the pending flag. On a read it returns the live request state of the source.

Six of the sources are external pins. Each pin passes through a two-flop synchronizer, and an edge detector then latches a pending flag. A polarity register selects rising or falling detection for each pin. A latched edge stays pending until software writes its field with bit 3 set. Because of this, the mask write (field value 0x8) acknowledges the source as well. The other 22 sources are level inputs from internal peripherals and need no acknowledge. Software usually masks everything after reset by writing 0x88888888 to all four registers, then unmasks sources one by one (for example, 0xD gives priority 5).

Top module: `nibprio_intc`

## Requirements
- R1: After reset every readable location reads zero, so every source is masked, and `irq_level` and `irq_src` are both zero.
- R2: Source i lives in control register i/8 (bus addresses 0 to 3), in bits [31-4*(i%8) -: 4]. Sources 0 to 3 are external pins 1 to 4, sources 25 and 26 are external pins 5 and 6, and all other sources are level inputs. A write to a field with bit 3 set loads bits 2:0 as that source's priority. A read returns the priority in bits 2:0 of the field.
- R3: A write to a field with bit 3 clear leaves that field's priority unchanged.
- R4: A source with priority 0 never appears on `irq_level` or `irq_src`.
- R5: A level source with a nonzero priority takes part in arbitration while its `int_req` bit is high, and drops out when the bit goes low. Reading bit 3 of its field returns its `int_req` bit.
- R6: An external pin is detected on a rising edge when its polarity bit is 1 and on a falling edge when the bit is 0. The polarity register is at address 4, and bit j-1 belongs to pin j. A detected edge sets a pending flag, which reads as bit 3 of the field three clock edges after the pin change is first sampled. The flag stays set after the pin returns to its old level.
- R7: A write with bit 3 set to an external source's field clears its pending flag. Writing 0x8 both masks and acknowledges the source.
- R8: An edge detected in the same cycle as an acknowledge write to that source leaves the flag pending.
- R9: `irq_level` is the highest priority among unmasked active sources. On a tie, the lowest source index wins. `irq_src` is the index of the winner, and it is 0 whenever `irq_level` is 0.
- R10: Bits 15:0 of register 3, bits 31:6 of the polarity register, and addresses 5 to 7 ignore writes and read as zero.
- R11: `int_req` bits at external source positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address: 0 to 3 control, 4 polarity |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ext_pin | input | 6 | Asynchronous external interrupt pins 1 to 6 |
| int_req | input | 28 | Level requests, indexed by source number |
| irq_level | output | 3 | Registered highest active priority |
| irq_src | output | 5 | Registered index of the winning source |

## Verification
Read data follows the address in the same cycle. A priority write is visible on a read right after the edge that takes it, and it shows up on the arbitration outputs one edge later. A level request reaches `irq_level` on the first edge after it changes. A pin change becomes a readable pending flag on the third edge and reaches the outputs on the fourth. The bench drives every input on a falling clock edge and counts exactly that many rising edges before it samples. For the coincidence case, it places the acknowledge write on exactly the edge where the pending flag would otherwise set.

// File: rtl/nibprio_pkg.sv
package nibprio_pkg;
  localparam int unsigned NUM_REGS       = 4;
  localparam int unsigned FIELDS_PER_REG = 8;
  localparam int unsigned FIELD_W        = 4;
  localparam int unsigned PRIO_W         = 3;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned ADDR_W         = 3;
  localparam int unsigned NUM_SRC        = 28;
  localparam int unsigned NUM_EXT        = 6;
  localparam int unsigned EXT_LOW_CNT    = 4;
  localparam int unsigned EXT_HIGH_BASE  = 25;
  localparam int unsigned SRC_W          = $clog2(NUM_SRC);
  localparam int unsigned POL_ADDR       = NUM_REGS;

  typedef logic [PRIO_W-1:0] prio_t;

  // source number owned by external pin j (0-based)
  function automatic int unsigned ext_src(input int unsigned j);
    return (j < EXT_LOW_CNT) ? j : (EXT_HIGH_BASE + j - EXT_LOW_CNT);
  endfunction

  // lowest bit of the field of source i inside its register
  function automatic int unsigned field_lo(input int unsigned i);
    return DATA_W - FIELD_W * ((i % FIELDS_PER_REG) + 1);
  endfunction
endpackage

// File: rtl/nibprio_edge_cap.sv
module nibprio_edge_cap
  import nibprio_pkg::*;
#(
  parameter int unsigned N_EXT = NUM_EXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] pin,
  input  logic [N_EXT-1:0] pol,
  input  logic [N_EXT-1:0] ack,
  output logic [N_EXT-1:0] edge_o,
  output logic [N_EXT-1:0] pend_o
);
  logic [N_EXT-1:0] meta_q, sync_q, last_q, pend_q;

  generate
    for (genvar j = 0; j < N_EXT; j++) begin : g_lane
      logic pend_d, pend_en;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[j] <= 1'b0;
          sync_q[j] <= 1'b0;
          last_q[j] <= 1'b0;
        end else begin
          meta_q[j] <= pin[j];
          sync_q[j] <= meta_q[j];
          last_q[j] <= sync_q[j];
        end
      end

      always_comb begin
        edge_o[j] = pol[j] ? (sync_q[j] & ~last_q[j]) : (~sync_q[j] & last_q[j]);
        pend_en   = edge_o[j] | ack[j];
        pend_d    = edge_o[j];              // a fresh edge outranks the acknowledge
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q[j] <= 1'b0;
        else if (pend_en) pend_q[j] <= pend_d;
      end
    end
  endgenerate

  assign pend_o = pend_q;
endmodule

// File: rtl/nibprio_regfile.sv
module nibprio_regfile
  import nibprio_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_SRC-1:0]             src_act,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_EXT-1:0]             pol_o,
  output logic [NUM_EXT-1:0]             ext_ack
);
  logic [NUM_SRC-1:0]             fwr;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_EXT-1:0]             pol_q;
  logic                           pol_we;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
      localparam int unsigned REG = i / FIELDS_PER_REG;
      localparam int unsigned LO  = field_lo(i);

      assign fwr[i] = bus_wr && (bus_addr == ADDR_W'(REG)) && bus_wdata[LO+PRIO_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prio_q[i] <= '0;
        else if (fwr[i]) prio_q[i] <= bus_wdata[LO +: PRIO_W];
      end
    end

    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ack
      assign ext_ack[j] = fwr[ext_src(j)];
    end
  endgenerate

  assign pol_we = bus_wr && (bus_addr == ADDR_W'(POL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= bus_wdata[NUM_EXT-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == ADDR_W'(i / FIELDS_PER_REG))
        bus_rdata[field_lo(i) +: FIELD_W] = {src_act[i], prio_q[i]};
    end
    if (bus_addr == ADDR_W'(POL_ADDR))
      bus_rdata[NUM_EXT-1:0] = pol_q;
  end

  assign prio_o = prio_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/nibprio_arb.sv
module nibprio_arb
  import nibprio_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [NUM_SRC-1:0]             act,
  output logic [PRIO_W-1:0]              level_o,
  output logic [SRC_W-1:0]               src_o
);
  prio_t            best_lvl;
  logic [SRC_W-1:0] best_idx;
  prio_t            level_q;
  logic [SRC_W-1:0] src_q;

  // ascending scan, strict compare: lower index keeps a tie, priority 0 never wins
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && (prio[i] > best_lvl)) begin
        best_lvl = prio[i];
        best_idx = SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      src_q   <= '0;
    end else begin
      level_q <= best_lvl;
      src_q   <= best_idx;
    end
  end

  assign level_o = level_q;
  assign src_o   = src_q;
endmodule

// File: rtl/nibprio_intc.sv
module nibprio_intc
  import nibprio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_EXT-1:0]    ext_pin,
  input  logic [NUM_SRC-1:0]    int_req,
  output logic [PRIO_W-1:0]     irq_level,
  output logic [SRC_W-1:0]      irq_src
);
  logic                           rst_meta_n, rst_sync_n;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
  logic [NUM_EXT-1:0]             pol_vec, ext_ack, ext_edge, ext_pend;
  logic [NUM_SRC-1:0]             src_act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    src_act = int_req;
    for (int j = 0; j < NUM_EXT; j++) src_act[ext_src(j)] = ext_pend[j];
  end

  nibprio_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_act   (src_act),
    .bus_rdata (bus_rdata),
    .prio_o    (prio_vec),
    .pol_o     (pol_vec),
    .ext_ack   (ext_ack)
  );

  nibprio_edge_cap #(.N_EXT(NUM_EXT)) u_edges (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin    (ext_pin),
    .pol    (pol_vec),
    .ack    (ext_ack),
    .edge_o (ext_edge),
    .pend_o (ext_pend)
  );

  nibprio_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .prio    (prio_vec),
    .act     (src_act),
    .level_o (irq_level),
    .src_o   (irq_src)
  );
endmodule

// File: rtl/nibprio_intc_chk.sv
module nibprio_intc_chk
  import nibprio_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [PRIO_W-1:0]              irq_level,
  input logic [SRC_W-1:0]               irq_src,
  input logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec,
  input logic [NUM_EXT-1:0]             ext_pend,
  input logic [NUM_EXT-1:0]             ext_ack,
  input logic [NUM_EXT-1:0]             ext_edge
);
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

  always_ff @(posedge clk) prio_q <= prio_vec;

  assert_idle_src_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_src == '0));

  assert_src_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src < SRC_W'(NUM_SRC));

  // the reported level belongs to the reported source and is never a masked one (R4)
  assert_level_matches_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_level == prio_q[irq_src]));

  assert_pending_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ext_pend & $past(ext_pend) & ~$past(ext_ack)) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_pend & $past(ext_ack & ~ext_edge)) == '0));

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ext_pend & $past(ext_edge)) == '0));
endmodule

bind nibprio_intc nibprio_intc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_level (irq_level),
  .irq_src   (irq_src),
  .prio_vec  (prio_vec),
  .ext_pend  (ext_pend),
  .ext_ack   (ext_ack),
  .ext_edge  (ext_edge)
);

// File: tb/sim_nibprio_intc.sv
`timescale 1ns/1ps
module sim_nibprio_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  ext_pin;
  logic [27:0] int_req;
  logic [2:0]  irq_level;
  logic [4:0]  irq_src;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nibprio_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .int_req(int_req), .irq_level(irq_level), .irq_src(irq_src)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] mask,
                      input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata & mask, exp);
  endtask

  task automatic ochk(input string req, input logic [2:0] lvl, input logic [4:0] src);
    chk(req, 32'({irq_src, irq_level}), 32'({src, lvl}));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) rchk("R1 reset read", 3'(a), '1, 32'h0);
    ochk("R1 reset outputs", 3'd0, 5'd0);
  endtask

  task automatic t_layout();
    wr(3'd0, 32'h89ABCDEF);
    rchk("R2 field layout", 3'd0, '1, 32'h01234567);
    wr(3'd0, 32'h0000000D);
    rchk("R3 bit3 clear keeps field", 3'd0, '1, 32'h01234565);
  endtask

  task automatic t_arbitrate();
    int_req = 28'h0A0;  // sources 5 and 7, both priority 5
    @(negedge clk);
    ochk("R9 tie goes to lower index", 3'd5, 5'd5);
    int_req = 28'h0E0;
    @(negedge clk);
    ochk("R9 highest priority wins", 3'd6, 5'd6);
    rchk("R5 read returns request level", 3'd0, '1, 32'h01234DED);
    int_req = 28'h0A0;
    @(negedge clk);
    ochk("R5 level source drops out", 3'd5, 5'd5);
    int_req = '0;
    @(negedge clk);
    ochk("R9 idle outputs", 3'd0, 5'd0);
  endtask

  task automatic t_mask();
    wr(3'd0, 32'h00000080);
    int_req = 28'h040;
    @(negedge clk);
    ochk("R4 masked source ignored", 3'd0, 5'd0);
    rchk("R4 masked field read", 3'd0, '1, 32'h01234585);
    int_req = '0;
  endtask

  task automatic t_ext_ignore();
    wr(3'd0, 32'hF0000000);
    int_req = 28'h1;
    @(negedge clk);
    @(negedge clk);
    ochk("R11 int_req at external slot ignored", 3'd0, 5'd0);
    rchk("R11 external slot reads no request", 3'd0, 32'hF0000000, 32'h70000000);
    int_req = '0;
  endtask

  task automatic t_rising();
    wr(3'd4, 32'h0000003F);
    ext_pin[0] = 1'b1;
    repeat (2) @(negedge clk);
    rchk("R6 pending not before third edge", 3'd0, 32'hF0000000, 32'h70000000);
    @(negedge clk);
    rchk("R6 rising edge pending", 3'd0, 32'hF0000000, 32'hF0000000);
    @(negedge clk);
    ochk("R6 pending edge reaches outputs", 3'd7, 5'd0);
    ext_pin[0] = 1'b0;
    repeat (5) @(negedge clk);
    rchk("R6 pending held after pin returns", 3'd0, 32'hF0000000, 32'hF0000000);
  endtask

  task automatic t_ack();
    wr(3'd0, 32'hF0000000);
    rchk("R7 ack clears pending", 3'd0, 32'hF0000000, 32'h70000000);
    @(negedge clk);
    ochk("R7 outputs drop after ack", 3'd0, 5'd0);
    ext_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    rchk("R7 second edge pending", 3'd0, 32'hF0000000, 32'hF0000000);
    wr(3'd0, 32'h80000000);
    rchk("R7 mask write acknowledges", 3'd0, 32'hF0000000, 32'h00000000);
    @(negedge clk);
    ochk("R7 masked and acked outputs", 3'd0, 5'd0);
  endtask

  task automatic t_falling();
    wr(3'd4, 32'h0000000F);
    ext_pin[4] = 1'b1;
    repeat (5) @(negedge clk);
    rchk("R6 rising ignored in falling mode", 3'd3, 32'h0F000000, 32'h0);
    wr(3'd3, 32'h0C000000);
    ext_pin[4] = 1'b0;
    repeat (2) @(negedge clk);
    rchk("R6 falling not yet pending", 3'd3, 32'h0F000000, 32'h04000000);
    @(negedge clk);
    rchk("R6 falling edge pending", 3'd3, 32'h0F000000, 32'h0C000000);
    @(negedge clk);
    ochk("R6 falling edge outputs", 3'd4, 5'd25);
    wr(3'd3, 32'h0C000000);
    rchk("R7 ack keeps priority", 3'd3, 32'h0F000000, 32'h04000000);
  endtask

  task automatic t_coincide();
    wr(3'd4, 32'h0000002F);
    wr(3'd3, 32'h00E00000);
    ext_pin[5] = 1'b1;
    @(negedge clk);
    wr(3'd3, 32'h00E00000);  // taken on the third edge, with the edge detection
    rchk("R8 edge beats simultaneous ack", 3'd3, 32'h00F00000, 32'h00E00000);
    wr(3'd3, 32'h00E00000);
    rchk("R7 later ack clears", 3'd3, 32'h00F00000, 32'h00600000);
  endtask

  task automatic t_unused();
    wr(3'd3, 32'h0000FFFF);
    rchk("R10 unused fields ignored", 3'd3, '1, 32'h04600000);
    wr(3'd5, 32'hFFFFFFFF);
    for (int a = 5; a < 8; a++) rchk("R10 unused address", 3'(a), '1, 32'h0);
    wr(3'd4, 32'hFFFFFFFF);
    rchk("R10 polarity upper bits", 3'd4, '1, 32'h0000003F);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_pin = '0; int_req = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_arbitrate();
    t_mask();
    t_ext_ignore();
    t_rising();
    t_ack();
    t_falling();
    t_coincide();
    t_unused();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule